// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes four shared PCI interrupt request lines and steers each one onto any of sixteen level-sensitive inputs of a legacy interrupt controller. Software picks the destination of each line by writing a byte-wide routing register through a small configuration port with byte enables. A routing value below sixteen selects that output number. Any value of sixteen or more disconnects the line.

Each output is the wired-OR of the levels of every line currently steered to it. Whenever a routing byte is written, all sixteen outputs are evaluated again from the live line levels, so moving a line clears its old destination at the same edge that drives the new one. Out of reset every line is disconnected.

Two helpers sit beside the router. A combinational swizzle turns a device's INTx pin and its device/function number into the shared line it uses, so that neighbouring slots rotate through the four lines. A combinational route query reports, for a chosen line, whether it is connected and to which output.

Top module: `pirq_router`

## Requirements
- R1: The swizzle output equals (intx + devfn[7:3] - 1) mod 4, where intx 0..3 stands for pins A..D and the result 0..3 stands for lines A..D.
- R2: The routing byte for line n (n = 0..3) sits at configuration byte address 0x60 + n, that is in byte lane n of the 32-bit word at address 0x60, and reads back as written.
- R3: After reset all four routing bytes read 0x80, every line is disconnected and all sixteen outputs are low.
- R4: A routing byte of 16 or more (for example 16, 0x80, 0xFF) disconnects its line: that line's level reaches no output.
- R5: Output k is high exactly when at least one line whose routing byte equals k has a high level.
- R6: Each line drives at most one output; the internal level map, indexed output × 4 + line, never holds more bits than there are lines.
- R7: Outputs are registered: they change at the first rising clock edge after a line level change or a routing write, and not before.
- R8: A routing write re-evaluates every output, so the old destination of a moved line falls at the same edge the new one rises.
- R9: The route query for line n returns enabled = 1 and target = the routing byte when that byte is below 16; otherwise enabled = 0 and target = 0.
- R10: A configuration write updates only the routing bytes whose byte-enable lane is set; a write to 0x60 with all four enables set updates all four bytes in one cycle.
- R11: Writes to any word address other than 0x60 change no routing byte and no output; reads from other word addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address; bits [7:2] pick the word |
| cfg_be | input | 4 | Byte-lane enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the word at cfg_addr (combinational) |
| pirq_lvl | input | 4 | Live levels of the four shared lines A..D |
| irq_out | output | 16 | Registered level outputs to the interrupt controller |
| q_pin | input | 2 | Line selected for the route query |
| q_en | output | 1 | Selected line is connected |
| q_target | output | 4 | Output number of the selected line, zero when disconnected |
| sw_intx | input | 2 | Device INTx pin for the swizzle (0 = A) |
| sw_devfn | input | 8 | Device/function number for the swizzle |
| sw_pirq | output | 2 | Shared line used by that pin (0 = A) |

## Verification
The hardest case to reach from the ports is several lines sharing one output while their routes and levels change at once, where the wired-OR must hold whichever line drops or leaves. The bench sweeps every routing value from 0 to 19 plus two high disconnect codes on each line, with all sixteen level patterns, then runs a long pseudo-random series of full-word writes whose bytes cluster in the 0..31 range so that collisions on the same output and disconnected lines both occur often. A focused sequence moves a lit line from one output to another to observe the old bit fall at the same edge.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Device swizzle: slot number is devfn[7:3]; lines rotate by slot.
  function automatic logic [1:0] slot_swizzle(input logic [1:0] intx,
                                               input logic [7:0] devfn);
    logic [4:0] sum;
    sum = 5'(intx) + devfn[7:3] - 5'd1;
    return sum[1:0];
  endfunction

  // A routing byte is live when it names an existing output.
  function automatic logic route_live(input logic [7:0] val, input int n_out);
    return int'(val) < n_out;
  endfunction

  // Bit position of (output, line) in the level map.
  function automatic int map_index(input logic [7:0] out_sel, input int line,
                                   input int n_line);
    return int'(out_sel) * n_line + line;
  endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle (
  input  logic [1:0] intx,
  input  logic [7:0] devfn,
  output logic [1:0] line
);
  import pirq_pkg::*;

  assign line = slot_swizzle(intx, devfn);

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
  parameter int          NUM_PIRQ   = 4,
  parameter int          NUM_OUT    = 16,
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter logic [7:0]  ROUTE_RST  = 8'h80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [7:0]                    addr,
  input  logic [3:0]                    be,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  input  logic [$clog2(NUM_PIRQ)-1:0]   q_pin,
  output logic                          q_en,
  output logic [$clog2(NUM_OUT)-1:0]    q_target,
  output logic [NUM_PIRQ-1:0][7:0]      route_nxt,
  output logic [NUM_PIRQ-1:0][7:0]      route_q,
  output logic                          route_wr
);
  import pirq_pkg::*;

  localparam int OW = $clog2(NUM_OUT);

  logic [NUM_PIRQ-1:0] hit;

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_byte
    localparam logic [7:0] BYTE_ADDR = 8'(ROUTE_BASE + 8'(i));
    localparam int         LANE      = int'(BYTE_ADDR[1:0]);

    assign hit[i]       = we && (addr[7:2] == BYTE_ADDR[7:2]) && be[LANE];
    assign route_nxt[i] = hit[i] ? wdata[LANE*8 +: 8] : route_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[i] <= ROUTE_RST;
      else        route_q[i] <= route_nxt[i];
    end
  end

  assign route_wr = |hit;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PIRQ; i++) begin
      logic [7:0] ba;
      ba = 8'(ROUTE_BASE + 8'(i));
      if (addr[7:2] == ba[7:2]) rdata[int'(ba[1:0])*8 +: 8] = route_q[i];
    end
  end

  assign q_en     = route_live(route_q[q_pin], NUM_OUT);
  assign q_target = q_en ? route_q[q_pin][OW-1:0] : '0;

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_OUT  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PIRQ-1:0][7:0]      route,
  input  logic [NUM_PIRQ-1:0]           lvl,
  output logic [NUM_OUT*NUM_PIRQ-1:0]   map_q,
  output logic [NUM_OUT-1:0]            irq_out
);
  import pirq_pkg::*;

  localparam int MAP_W = NUM_OUT * NUM_PIRQ;

  logic [MAP_W-1:0]   map_d;
  logic [NUM_OUT-1:0] out_d;

  // Map is rebuilt from scratch every cycle from live levels and routes.
  always_comb begin
    map_d = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (route_live(route[p], NUM_OUT))
        map_d[map_index(route[p], p, NUM_PIRQ)] = lvl[p];
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign out_d[k] = |map_d[k*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= '0;
      irq_out <= '0;
    end else begin
      map_q   <= map_d;
      irq_out <= out_d;
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int         NUM_PIRQ   = 4,
  parameter int         NUM_OUT    = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_addr,
  input  logic [3:0]                    cfg_be,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  input  logic [NUM_PIRQ-1:0]           pirq_lvl,
  output logic [NUM_OUT-1:0]            irq_out,
  input  logic [$clog2(NUM_PIRQ)-1:0]   q_pin,
  output logic                          q_en,
  output logic [$clog2(NUM_OUT)-1:0]    q_target,
  input  logic [1:0]                    sw_intx,
  input  logic [7:0]                    sw_devfn,
  output logic [1:0]                    sw_pirq
);

  logic [NUM_PIRQ-1:0][7:0]    route_nxt;
  logic [NUM_PIRQ-1:0][7:0]    route_q;
  logic                        route_wr;
  logic [NUM_OUT*NUM_PIRQ-1:0] level_map;

  pirq_swizzle u_swz (
    .intx  (sw_intx),
    .devfn (sw_devfn),
    .line  (sw_pirq)
  );

  pirq_route_regs #(
    .NUM_PIRQ   (NUM_PIRQ),
    .NUM_OUT    (NUM_OUT),
    .ROUTE_BASE (ROUTE_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .q_pin     (q_pin),
    .q_en      (q_en),
    .q_target  (q_target),
    .route_nxt (route_nxt),
    .route_q   (route_q),
    .route_wr  (route_wr)
  );

  pirq_level_map #(
    .NUM_PIRQ (NUM_PIRQ),
    .NUM_OUT  (NUM_OUT)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (route_nxt),
    .lvl     (pirq_lvl),
    .map_q   (level_map),
    .irq_out (irq_out)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_OUT  = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic                        route_wr,
  input logic [NUM_PIRQ-1:0]         pirq_lvl,
  input logic [NUM_OUT-1:0]          irq_out,
  input logic [NUM_OUT*NUM_PIRQ-1:0] level_map
);

  p_reset_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0));

  p_one_bit_per_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(level_map) <= NUM_PIRQ);

  p_out_needs_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_map == '0) |-> (irq_out == '0));

  p_no_level_no_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == '0) |=> (irq_out == '0));

  p_quiet_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && $stable(pirq_lvl)) |=> $stable(irq_out));

  p_strobe_gates_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr |-> cfg_we);

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ (NUM_PIRQ),
  .NUM_OUT  (NUM_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .route_wr  (route_wr),
  .pirq_lvl  (pirq_lvl),
  .irq_out   (irq_out),
  .level_map (level_map)
);

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h60;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_lvl = 4'h0;
  logic [15:0] irq_out;
  logic [1:0]  q_pin = 2'd0;
  logic        q_en;
  logic [3:0]  q_target;
  logic [1:0]  sw_intx = 2'd0;
  logic [7:0]  sw_devfn = 8'd0;
  logic [1:0]  sw_pirq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [7:0] rt [4];

  always #2.5 clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pirq_lvl(pirq_lvl), .irq_out(irq_out), .q_pin(q_pin), .q_en(q_en),
    .q_target(q_target), .sw_intx(sw_intx), .sw_devfn(sw_devfn),
    .sw_pirq(sw_pirq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_out(input logic [3:0] lv);
    logic [15:0] o = '0;
    for (int p = 0; p < 4; p++)
      if (rt[p] < 8'd16 && lv[p]) o[rt[p][3:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] model_word();
    return {rt[3], rt[2], rt[1], rt[0]};
  endfunction

  // Drive at a falling edge, return at the falling edge after the write edge.
  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
    if (a[7:2] == 6'h18)
      for (int i = 0; i < 4; i++) if (be[i]) rt[i] = d[i*8 +: 8];
  endtask

  task automatic set_lvl(input logic [3:0] v);
    pirq_lvl = v;
    @(negedge clk);
  endtask

  task automatic chk_query(input string req);
    for (int p = 0; p < 4; p++) begin
      q_pin = 2'(p);
      #0.1;
      chk(req, {27'd0, q_en, q_target},
          {27'd0, (rt[p] < 8'd16), (rt[p] < 8'd16) ? rt[p][3:0] : 4'd0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 4; i++) rt[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    cfg_addr = 8'h60; #0.1;
    chk("R3 reset bytes", cfg_rdata, 32'h80808080);
    chk("R3 reset outputs", {16'd0, irq_out}, 32'd0);
    chk_query("R9 reset query");
    set_lvl(4'hF);
    chk("R3 disabled lines", {16'd0, irq_out}, 32'd0);

    // R1 exhaustive swizzle
    for (int ix = 0; ix < 4; ix++)
      for (int df = 0; df < 256; df++) begin
        sw_intx = 2'(ix); sw_devfn = 8'(df); #0.1;
        chk("R1 swizzle", {30'd0, sw_pirq}, 32'((ix + (df >> 3) + 3) % 4));
      end

    // R2/R4/R5/R9 sweep per line and value
    for (int p = 0; p < 4; p++) begin
      for (int vi = 0; vi < 22; vi++) begin
        logic [7:0] v;
        v = (vi < 20) ? 8'(vi) : ((vi == 20) ? 8'h80 : 8'hFF);
        wr(8'h60, 4'(1 << p), 32'(v) << (8 * p));
        cfg_addr = 8'h60; #0.1;
        chk("R2 readback", cfg_rdata, model_word());
        chk_query("R9 query");
        for (int m = 0; m < 16; m++) begin
          set_lvl(4'(m));
          chk((v >= 8'd16) ? "R4 disconnect" : "R5 route", {16'd0, irq_out},
              {16'd0, model_out(4'(m))});
        end
      end
      wr(8'h60, 4'(1 << p), 32'h80 << (8 * p));
    end

    // R10 full-word write, then a partial one
    wr(8'h60, 4'hF, 32'h05_05_02_07);
    #0.1; chk("R10 full word", cfg_rdata, 32'h05050207);
    set_lvl(4'hF);
    chk("R5 shared output", {16'd0, irq_out}, {16'd0, model_out(4'hF)});
    set_lvl(4'b0100);
    chk("R5 shared one high", {16'd0, irq_out}, 32'h20);
    wr(8'h60, 4'b0101, 32'hAA_0B_BB_0C);
    #0.1; chk("R10 partial lanes", cfg_rdata, 32'h050B020C);
    chk("R10 partial outputs", {16'd0, irq_out}, {16'd0, model_out(pirq_lvl)});

    // R11 other addresses ignored
    set_lvl(4'hF);
    wr(8'h64, 4'hF, 32'h00000000);
    wr(8'h5C, 4'hF, 32'h01010101);
    cfg_addr = 8'h60; #0.1;
    chk("R11 bytes kept", cfg_rdata, 32'h050B020C);
    chk("R11 outputs kept", {16'd0, irq_out}, {16'd0, model_out(4'hF)});
    cfg_addr = 8'h64; #0.1;
    chk("R11 other read", cfg_rdata, 32'd0);
    cfg_addr = 8'h60;

    // R7 latency and R8 move
    wr(8'h60, 4'hF, 32'h80808003);
    set_lvl(4'b0001);
    chk("R7 settled", {16'd0, irq_out}, 32'h8);
    pirq_lvl = 4'b0000; #0.5;
    chk("R7 no early change", {16'd0, irq_out}, 32'h8);
    @(negedge clk);
    chk("R7 change at edge", {16'd0, irq_out}, 32'h0);
    set_lvl(4'b0001);
    @(negedge clk);
    cfg_we = 1'b1; cfg_be = 4'h1; cfg_wdata = 32'h9; #0.5;
    chk("R7 write not early", {16'd0, irq_out}, 32'h8);
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0; rt[0] = 8'h9;
    chk("R8 move same edge", {16'd0, irq_out}, 32'h200);

    // R5/R6 pseudo-random collisions
    lfsr = 32'hACE1_2B4D;
    for (int it = 0; it < 400; it++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(8'h60, 4'hF, lfsr & 32'h1F1F1F1F);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      set_lvl(lfsr[3:0]);
      chk("R5 random", {16'd0, irq_out}, {16'd0, model_out(lfsr[3:0])});
      #0.1; chk("R2 random readback", cfg_rdata, model_word());
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule